// File: doc/BRIEF.md
# Descriptor Chain Walker

This block walks a descriptor ROM that sits behind a simple byte-wide read port. On a start pulse it reads a 10-bit length field from the ROM header and derives the total ROM size from it. It then follows a chain of variable-length entries that begins right after the fixed 22-byte header. Each entry states its own length, so the position of the next entry is always found by adding that length to the current position.

For every entry it accepts, the block emits one single-cycle record. The record holds the entry's type (generic or port), its 6-bit index, its disabled flag and its length. It also holds two derived values: whether the entry is a port beyond the configured port count, and the name-string length for the two generic entries that carry names. Every step is bounds-checked against the declared size. A malformed chain stops the walk, and a coded error is reported on the done pulse.

Downstream logic consumes the records as they stream out. It uses the final code to decide whether to trust the list.

Top module: `dcw_walker`

## Requirements
- R1: The total size is the 10-bit value formed by ROM byte 14 (bits 7:0) and bits 1:0 of ROM byte 15 (bits 9:8), plus 13. Bits 7:2 of byte 15 have no effect. The size is shown on `total_size` from the first entry read onward.
- R2: A total size below 22 ends the walk with error code 1, and no entry is read or emitted.
- R3: Entry traversal starts at position 22. When the position reaches or passes the total size, the walk ends with code 0. A size of exactly 22 therefore yields no entries and code 0.
- R4: An entry occupies two header bytes. The byte at the position is the length. The byte after it holds the index in bits 5:0, the disabled flag in bit 6 and the type in bit 7 (1 = port, 0 = generic). Each accepted entry produces one `ent_valid` cycle carrying these fields, in chain order, and the position then advances by the length.
- R5: When the position plus one equals the total size, the walk ends with code 2 before any read at that position.
- R6: An entry length of zero ends the walk with code 3.
- R7: An entry whose position plus length exceeds the total size ends the walk with code 4.
- R8: A port entry whose index is greater than `max_port` is emitted with `ent_ignored`=1 and never raises code 5, whatever its length.
- R9: A port entry that is not ignored and not disabled must have length 8. Any other length ends the walk with code 5. Disabled ports may have any nonzero in-range length.
- R10: For a generic entry with index 1 or 2 and length of at least 2, `ent_name_len` is the length minus 2. For every other entry it is 0.
- R11: An entry that raises an error is not emitted. `busy` is high from the cycle after start until the walk ends. `done` is high for exactly one cycle per walk. A start pulse during a walk has no effect.
- R12: Read data arrives one cycle after `mem_rd`. A walk makes two header reads, at addresses 14 then 15. It then makes two reads per examined entry, at the position and the position plus one, and every entry read addresses a byte below the total size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| max_port | input | 6 | Highest valid port index |
| mem_rd | output | 1 | ROM read strobe |
| mem_addr | output | ADDR_W | ROM byte address |
| mem_data | input | 8 | ROM byte, valid the cycle after `mem_rd` |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err_code | output | 3 | 0 ok, 1 short, 2 dangling byte, 3 zero length, 4 overrun, 5 port length |
| total_size | output | ADDR_W | Derived ROM size |
| ent_valid | output | 1 | Entry record valid |
| ent_is_port | output | 1 | Entry type is port |
| ent_disabled | output | 1 | Entry disabled flag |
| ent_index | output | 6 | Entry index |
| ent_len | output | 8 | Entry length including header |
| ent_ignored | output | 1 | Port beyond `max_port` |
| ent_name_len | output | 8 | Name string length for named generic entries |

## Verification
The cycle-level assertions cover the properties of each record: an emitted entry never has zero length, an enabled and counted port is always 8 bytes, ignored ports really exceed `max_port`, and the name length matches the entry length. They also cover the read-port discipline and the single-cycle done pulse. Which error code a given chain produces, the order and number of emitted records, and the exact read count can only be shown by the bench. It sweeps the length field and chain shapes and compares each walk against an arithmetic walk of the same ROM image.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  localparam int HDR_BYTES      = 22;
  localparam int SIZE_BIAS      = 13;
  localparam int LEN_LO_OFS     = 14;
  localparam int LEN_HI_OFS     = 15;
  localparam int LEN_FIELD_W    = 10;
  localparam int PORT_ENTRY_LEN = 8;
  localparam int IDX_W          = 6;
  localparam int NAME_VENDOR_IDX = 1;
  localparam int NAME_DEVICE_IDX = 2;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_SHORT   = 3'd1,
    ERR_DANGLE  = 3'd2,
    ERR_ZERO    = 3'd3,
    ERR_OVERRUN = 3'd4,
    ERR_PORTLEN = 3'd5
  } dcw_err_e;

  typedef enum logic [2:0] {
    S_IDLE, S_H_LO, S_H_HI, S_H_END, S_E_CHK, S_E_LEN, S_E_FLG, S_DONE
  } dcw_state_e;

  typedef struct packed {
    logic             is_port;
    logic             disabled;
    logic [IDX_W-1:0] index;
  } dcw_flags_t;
endpackage

// File: rtl/dcw_size_calc.sv
module dcw_size_calc
  import dcw_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [7:0]        len_lo,
  input  logic [7:0]        len_hi,
  output logic [ADDR_W-1:0] rom_size,
  output logic              too_small
);
  logic [LEN_FIELD_W-1:0] field;

  always_comb begin
    field     = {len_hi[LEN_FIELD_W-9:0], len_lo};
    rom_size  = ADDR_W'(field) + ADDR_W'(SIZE_BIAS);
    too_small = rom_size < ADDR_W'(HDR_BYTES);
  end
endmodule

// File: rtl/dcw_entry_eval.sv
module dcw_entry_eval
  import dcw_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] pos,
  input  logic [ADDR_W-1:0] rom_size,
  input  logic [7:0]        len,
  input  dcw_flags_t        flags,
  input  logic [IDX_W-1:0]  max_port,
  output dcw_err_e          err,
  output logic              ignored,
  output logic [7:0]        name_len
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] end_pos;
  logic             named;

  always_comb begin
    end_pos  = {1'b0, pos} + {{(EXT_W-8){1'b0}}, len};
    ignored  = flags.is_port && (flags.index > max_port);
    named    = !flags.is_port &&
               ((flags.index == IDX_W'(NAME_VENDOR_IDX)) ||
                (flags.index == IDX_W'(NAME_DEVICE_IDX)));
    name_len = (named && (len >= 8'd2)) ? (len - 8'd2) : 8'd0;

    if (len == 8'd0) begin
      err = ERR_ZERO;
    end else if (end_pos > {1'b0, rom_size}) begin
      err = ERR_OVERRUN;
    end else if (flags.is_port && !ignored && !flags.disabled &&
                 (len != 8'(PORT_ENTRY_LEN))) begin
      err = ERR_PORTLEN;
    end else begin
      err = ERR_NONE;
    end
  end
endmodule

// File: rtl/dcw_walker.sv
module dcw_walker
  import dcw_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [5:0]        max_port,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err_code,
  output logic [ADDR_W-1:0] total_size,
  output logic              ent_valid,
  output logic              ent_is_port,
  output logic              ent_disabled,
  output logic [5:0]        ent_index,
  output logic [7:0]        ent_len,
  output logic              ent_ignored,
  output logic [7:0]        ent_name_len
);
  localparam int EXT_W = ADDR_W + 1;

  dcw_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pos_q, pos_d;
  logic [ADDR_W-1:0] size_q, size_d;
  logic [7:0]        lo_q, lo_d;
  logic [7:0]        len_q, len_d;
  dcw_err_e          err_q, err_d;
  logic              ent_load;

  logic [ADDR_W-1:0] calc_size;
  logic              calc_small;
  dcw_err_e          ev_err;
  logic              ev_ignored;
  logic [7:0]        ev_name_len;
  dcw_flags_t        flags_in;

  logic              ent_valid_q;
  dcw_flags_t        ent_flags_q;
  logic [7:0]        ent_len_q;
  logic              ent_ignored_q;
  logic [7:0]        ent_name_q;

  assign flags_in = dcw_flags_t'(mem_data);

  dcw_size_calc #(.ADDR_W(ADDR_W)) u_size (
    .len_lo    (lo_q),
    .len_hi    (mem_data),
    .rom_size  (calc_size),
    .too_small (calc_small)
  );

  dcw_entry_eval #(.ADDR_W(ADDR_W)) u_eval (
    .pos      (pos_q),
    .rom_size (size_q),
    .len      (len_q),
    .flags    (flags_in),
    .max_port (max_port),
    .err      (ev_err),
    .ignored  (ev_ignored),
    .name_len (ev_name_len)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    pos_d    = pos_q;
    size_d   = size_q;
    lo_d     = lo_q;
    len_d    = len_q;
    err_d    = err_q;
    mem_rd   = 1'b0;
    mem_addr = '0;
    ent_load = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          err_d   = ERR_NONE;
          state_d = S_H_LO;
        end
      end
      S_H_LO: begin
        mem_rd   = 1'b1;
        mem_addr = ADDR_W'(LEN_LO_OFS);
        state_d  = S_H_HI;
      end
      S_H_HI: begin
        lo_d     = mem_data;
        mem_rd   = 1'b1;
        mem_addr = ADDR_W'(LEN_HI_OFS);
        state_d  = S_H_END;
      end
      S_H_END: begin
        size_d = calc_size;
        pos_d  = ADDR_W'(HDR_BYTES);
        if (calc_small) begin
          err_d   = ERR_SHORT;
          state_d = S_DONE;
        end else begin
          state_d = S_E_CHK;
        end
      end
      S_E_CHK: begin
        if (pos_q >= size_q) begin
          state_d = S_DONE;
        end else if (({1'b0, pos_q} + EXT_W'(1)) == {1'b0, size_q}) begin
          err_d   = ERR_DANGLE;
          state_d = S_DONE;
        end else begin
          mem_rd   = 1'b1;
          mem_addr = pos_q;
          state_d  = S_E_LEN;
        end
      end
      S_E_LEN: begin
        len_d    = mem_data;
        mem_rd   = 1'b1;
        mem_addr = pos_q + ADDR_W'(1);
        state_d  = S_E_FLG;
      end
      S_E_FLG: begin
        if (ev_err != ERR_NONE) begin
          err_d   = ev_err;
          state_d = S_DONE;
        end else begin
          ent_load = 1'b1;
          pos_d    = pos_q + ADDR_W'(len_q);
          state_d  = S_E_CHK;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pos_q   <= '0;
      size_q  <= '0;
      lo_q    <= '0;
      len_q   <= '0;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      size_q  <= size_d;
      lo_q    <= lo_d;
      len_q   <= len_d;
      err_q   <= err_d;
    end
  end

  // entry record registers, enabled by ent_load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid_q   <= 1'b0;
      ent_flags_q   <= '0;
      ent_len_q     <= '0;
      ent_ignored_q <= 1'b0;
      ent_name_q    <= '0;
    end else begin
      ent_valid_q <= ent_load;
      if (ent_load) begin
        ent_flags_q   <= flags_in;
        ent_len_q     <= len_q;
        ent_ignored_q <= ev_ignored;
        ent_name_q    <= ev_name_len;
      end
    end
  end

  assign busy         = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done         = (state_q == S_DONE);
  assign err_code     = err_q;
  assign total_size   = size_q;
  assign ent_valid    = ent_valid_q;
  assign ent_is_port  = ent_flags_q.is_port;
  assign ent_disabled = ent_flags_q.disabled;
  assign ent_index    = ent_flags_q.index;
  assign ent_len      = ent_len_q;
  assign ent_ignored  = ent_ignored_q;
  assign ent_name_len = ent_name_q;
endmodule

// File: rtl/dcw_walker_chk.sv
module dcw_walker_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:0]        max_port,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              done,
  input logic [2:0]        err_code,
  input logic [ADDR_W-1:0] total_size,
  input logic              ent_valid,
  input logic              ent_is_port,
  input logic              ent_disabled,
  input logic [5:0]        ent_index,
  input logic [7:0]        ent_len,
  input logic              ent_ignored,
  input logic [7:0]        ent_name_len
);
  AST_SHORT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (total_size < ADDR_W'(22))) |-> (err_code == 3'd1)); // R2

  AST_ENTRY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> (ent_len != 8'd0)); // R6

  AST_ENTRY_IN_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && (mem_addr >= ADDR_W'(16))) |-> (mem_addr < total_size)); // R12

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd); // R12

  AST_IGNORED_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_ignored) |-> (ent_is_port && (ent_index > max_port))); // R8

  AST_PORT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_is_port && !ent_ignored && !ent_disabled) |-> (ent_len == 8'd8)); // R9

  AST_NAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && (ent_name_len != 8'd0)) |->
      (!ent_is_port && (ent_len == ent_name_len + 8'd2))); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_EMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> busy); // R11
endmodule

bind dcw_walker dcw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .max_port     (max_port),
  .mem_rd       (mem_rd),
  .mem_addr     (mem_addr),
  .busy         (busy),
  .done         (done),
  .err_code     (err_code),
  .total_size   (total_size),
  .ent_valid    (ent_valid),
  .ent_is_port  (ent_is_port),
  .ent_disabled (ent_disabled),
  .ent_index    (ent_index),
  .ent_len      (ent_len),
  .ent_ignored  (ent_ignored),
  .ent_name_len (ent_name_len)
);

// File: tb/dcw_walker_tb.sv
module dcw_walker_tb;
  localparam int AW = 11;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [5:0]    max_port;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data;
  logic          busy, done;
  logic [2:0]    err_code;
  logic [AW-1:0] total_size;
  logic          ent_valid, ent_is_port, ent_disabled, ent_ignored;
  logic [5:0]    ent_index;
  logic [7:0]    ent_len, ent_name_len;

  logic [7:0] rom [0:2047];

  int checks, fails, cyc;
  int got_n, rd_cnt;
  int got_len [0:1023];
  int got_flg [0:1023];
  int got_ign [0:1023];
  int got_nam [0:1023];
  int exp_n, exp_err, exp_size, exp_rd;
  int exp_len [0:1023];
  int exp_flg [0:1023];
  int exp_ign [0:1023];
  int exp_nam [0:1023];
  logic [31:0] rng;

  dcw_walker #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .max_port(max_port),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
    .busy(busy), .done(done), .err_code(err_code), .total_size(total_size),
    .ent_valid(ent_valid), .ent_is_port(ent_is_port), .ent_disabled(ent_disabled),
    .ent_index(ent_index), .ent_len(ent_len), .ent_ignored(ent_ignored),
    .ent_name_len(ent_name_len)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) if (mem_rd) mem_data <= rom[mem_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL R11 watchdog actual=%0d expected<=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic string tag_for(input int code);
    case (code)
      0: return "R3";
      1: return "R2";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // arithmetic walk of the ROM image, written from the requirements
  task automatic model(input int maxp);
    int pos, len, fl, port, idx, dis, ign;
    exp_size = {rom[15][1:0], rom[14]} + 13;
    exp_n = 0;
    exp_err = 0;
    exp_rd = 2;
    if (exp_size < 22) begin
      exp_err = 1;
      return;
    end
    pos = 22;
    while (pos < exp_size) begin
      if (pos + 1 == exp_size) begin exp_err = 2; break; end
      exp_rd = exp_rd + 2;
      len  = rom[pos];
      fl   = rom[pos + 1];
      port = (fl >> 7) & 1;
      dis  = (fl >> 6) & 1;
      idx  = fl & 63;
      ign  = (port == 1 && idx > maxp) ? 1 : 0;
      if (len == 0) begin exp_err = 3; break; end
      if (pos + len > exp_size) begin exp_err = 4; break; end
      if (port == 1 && ign == 0 && dis == 0 && len != 8) begin exp_err = 5; break; end
      exp_len[exp_n] = len;
      exp_flg[exp_n] = fl;
      exp_ign[exp_n] = ign;
      exp_nam[exp_n] = (port == 0 && (idx == 1 || idx == 2) && len >= 2) ? len - 2 : 0;
      exp_n = exp_n + 1;
      pos = pos + len;
    end
  endtask

  task automatic run_walk(input bit mid_start);
    int it;
    got_n = 0;
    rd_cnt = 0;
    it = 0;
    @(negedge clk);
    start = 1'b1;
    forever begin
      @(negedge clk);
      start = (mid_start && (it == 4)) ? 1'b1 : 1'b0;
      if (it == 0) chk(busy == 1'b1, "R11", int'(busy), 1);
      if (ent_valid) begin
        got_len[got_n] = ent_len;
        got_flg[got_n] = {ent_is_port, ent_disabled, ent_index};
        got_ign[got_n] = ent_ignored;
        got_nam[got_n] = ent_name_len;
        got_n = got_n + 1;
      end
      if (mem_rd) rd_cnt = rd_cnt + 1;
      if (done) break;
      it = it + 1;
    end
    start = 1'b0;
    chk(busy == 1'b0, "R11", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", int'(done), 0);
  endtask

  task automatic run_and_compare(input bit mid_start);
    int lim;
    model(int'(max_port));
    run_walk(mid_start);
    chk(int'(err_code) == exp_err, tag_for(exp_err), int'(err_code), exp_err);
    if (exp_err != 1) chk(int'(total_size) == exp_size, "R1", int'(total_size), exp_size);
    chk(got_n == exp_n, "R4", got_n, exp_n);
    chk(rd_cnt == exp_rd, "R12", rd_cnt, exp_rd);
    lim = (got_n < exp_n) ? got_n : exp_n;
    for (int i = 0; i < lim; i++) begin
      chk(got_len[i] == exp_len[i], "R4", got_len[i], exp_len[i]);
      chk(got_flg[i] == exp_flg[i], "R4", got_flg[i], exp_flg[i]);
      chk(got_ign[i] == exp_ign[i], "R8", got_ign[i], exp_ign[i]);
      chk(got_nam[i] == exp_nam[i], "R10", got_nam[i], exp_nam[i]);
    end
  endtask

  task automatic set_len(input int dl);
    rng = step(rng);
    rom[14] = dl[7:0];
    rom[15] = {rng[7:2], dl[9:8]};
  endtask

  task automatic fill_body(input int size);
    int p, len;
    p = 22;
    while (p < size + 2 && p < 2040) begin
      rng = step(rng);
      len = 2 + int'(rng[10:8] % 3'd7);
      if (rng[20:16] == 5'd3) len = 0;
      if (rng[25:21] == 5'd7) len = 60;
      rom[p]     = len[7:0];
      rom[p + 1] = {rng[31], rng[30], 3'b000, rng[2:0]};
      for (int k = 2; k < len && p + k < 2048; k++) rom[p + k] = rng[7:0] ^ k[7:0];
      p = p + ((len < 2) ? 2 : len);
    end
  endtask

  initial begin
    checks = 0; fails = 0; cyc = 0;
    rng = 32'h1234_5678;
    start = 1'b0;
    max_port = 6'd5;
    for (int i = 0; i < 2048; i++) rom[i] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // reset state
    chk(busy == 1'b0, "R11", int'(busy), 0);
    chk(done == 1'b0, "R11", int'(done), 0);
    chk(ent_valid == 1'b0, "R4", int'(ent_valid), 0);
    chk(mem_rd == 1'b0, "R12", int'(mem_rd), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3 boundary: size 21 short, size 22 empty and ok, size 23 dangling (R5)
    set_len(8);  run_and_compare(1'b0);
    chk(int'(err_code) == 1, "R2", int'(err_code), 1);
    set_len(9);  run_and_compare(1'b0);
    chk(int'(err_code) == 0 && got_n == 0, "R3", got_n, 0);
    set_len(10); run_and_compare(1'b0);
    chk(int'(err_code) == 2, "R5", int'(err_code), 2);

    // R8: out-of-range port with odd length is emitted and ignored
    set_len(28);
    rom[22] = 8'd3; rom[23] = 8'h89;
    rom[25] = 8'd8; rom[26] = 8'h83;
    rom[33] = 8'd8; rom[34] = 8'hC4;
    run_and_compare(1'b0);
    chk(int'(err_code) == 0 && got_n == 3, "R8", got_n, 3);
    chk(got_ign[0] == 1, "R8", got_ign[0], 1);

    // R9: enabled port with length 7 fails
    set_len(27);
    rom[25] = 8'd7; rom[26] = 8'h83;
    rom[32] = 8'd8; rom[33] = 8'hC4;
    run_and_compare(1'b0);
    chk(int'(err_code) == 5 && got_n == 1, "R9", int'(err_code), 5);

    // R9: disabled port of length 3 accepted
    set_len(12);
    rom[22] = 8'd3; rom[23] = 8'hC2;
    run_and_compare(1'b0);
    chk(int'(err_code) == 0 && got_n == 1, "R9", int'(err_code), 0);

    // R10: named generic entries; R11: start during a walk is ignored
    set_len(22);
    rom[22] = 8'd6; rom[23] = 8'h01;
    rom[28] = 8'd2; rom[29] = 8'h02;
    rom[30] = 8'd5; rom[31] = 8'h03;
    run_and_compare(1'b1);
    chk(got_n == 3 && got_nam[0] == 4, "R10", got_nam[0], 4);

    // R6 and R7 directed
    set_len(20);
    rom[22] = 8'd0; rom[23] = 8'h01;
    run_and_compare(1'b0);
    chk(int'(err_code) == 3, "R6", int'(err_code), 3);
    set_len(20);
    rom[22] = 8'd4; rom[23] = 8'h01;
    rom[26] = 8'd9; rom[27] = 8'h01;
    run_and_compare(1'b0);
    chk(int'(err_code) == 4 && got_n == 1, "R7", int'(err_code), 4);

    // sweep of length field and chain shapes, random upper bits of byte 15 (R1)
    for (int dl = 0; dl < 48; dl++) begin
      for (int v = 0; v < 4; v++) begin
        max_port = 6'(v + 3);
        set_len(dl);
        fill_body(dl + 13);
        run_and_compare(v == 2);
      end
    end
    // large regions
    max_port = 6'd7;
    foreach (rom[i]) rom[i] = 8'h00;
    set_len(1023); fill_body(1036); run_and_compare(1'b0);
    set_len(600);  fill_body(613);  run_and_compare(1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule